// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block holds a calendar time (seconds, minutes, hours, day of month, weekday, month and a two-digit year) as packed BCD bytes. A one-cycle pulse on the per-second tick input moves the time forward by one second. Each carry ripples up through the fields in the same cycle, with month lengths and leap years taken into account. A byte-wide register port reads and writes the fields. The port reads asynchronously and writes on the clock edge. It stands in for the serial bus that software would normally use.

A control byte selects the hour format and can freeze counting. In 24-hour format the hours byte counts 00 to 23. In 12-hour format it counts 12, 01, ..., 11 and carries a PM bit. The top bit of the seconds byte is a sticky flag that reports a lost oscillator. An external fail pulse sets it, and software clears it when it rewrites the seconds.

Top module: `bcd_calendar_regs`

## Requirements
- R1: After reset the bytes read as follows: control 0x00, seconds 0x80 (integrity flag set), minutes 0x00, hours 0x00, date 0x01, weekday 0x00, month 0x01, year 0x00.
- R2: The control byte is at address 0x00 and uses only bit 3 (12-hour format) and bit 5 (stop). The time bytes are at 0x03 to 0x09 in the order seconds, minutes, hours, date, weekday, month, year. Writable widths are 7, 7, 6, 6, 3, 5 and 8 bits. Bits above a field read as zero. Any other address reads 0x00 and ignores writes.
- R3: Bit 7 of the seconds byte is set by a pulse on osc_fail and stays set. It is cleared only by a seconds write with bit 7 at 0. A write with bit 7 at 1 leaves it set. When a fail pulse and a clearing write arrive together, the flag stays set.
- R4: While control bit 5 is 1, ticks do not change any time byte, but register writes still take effect.
- R5: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R6: With control bit 3 at 0, hours count 00 to 23 in BCD, and 23 to 00 advances the day.
- R7: With control bit 3 at 1, hours bits 4:0 hold a BCD value from 01 to 12 and bit 5 is PM. The sequence 11 to 12 toggles PM, 12 goes to 01, and 11 PM to 12 AM advances the day. Changing the format does not convert the stored hours.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. In month 02 it wraps after 29 when the year is divisible by 4 (including 00), and after 28 otherwise. Each wrap advances the month.
- R9: The weekday counts 0 to 6 and wraps, advancing once per day. The month goes 12 to 01 with a year carry, and the year goes 99 to 00.
- R10: A write in the same cycle as a tick sets the addressed field to the written value, and that field does not advance. The other fields still advance as they would from their values before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| osc_fail | input | 1 | Pulse reporting an oscillator interruption |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr (combinational) |

## Verification
Any carry decision is visible at the register port on the read that follows the tick that crosses the boundary. The bench therefore places the time one second before each rollover boundary: minute, day, 12-hour noon and midnight, each month length, the leap and non-leap February, and the end of the year. It then reads every affected byte after a single tick. A wrong internal flag or a wrong mode bit shows up on the first read of the seconds or hours byte. Same-cycle write and tick collisions are driven explicitly, so a priority error appears in the very next read of the written field and of its neighbour.

// File: rtl/bcd_calendar_regs.sv
module bcd_calendar_regs #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              osc_fail,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_WD   = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_YR   = ADDR_W'(9);

  logic       ctrl_12h, ctrl_stop, osc_q;
  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, date_q;
  logic [2:0] wd_q;
  logic [4:0] mon_q;
  logic [7:0] yr_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic       adv, c_min, c_hr, c_day, c_mon, c_yr, leap, hr_top;
  logic [5:0] last_date, hr_nx;
  logic [7:0] sec_i, min_i, hr_i, hr12_i, date_i, mon_i, yr_i;

  assign adv   = tick_1hz & ~ctrl_stop;
  assign leap  = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                         : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);
  assign hr_top = ctrl_12h ? (hr_q == 6'h31) : (hr_q == 6'h23);
  assign c_min = adv & (sec_q == 7'h59);
  assign c_hr  = c_min & (min_q == 7'h59);
  assign c_day = c_hr & hr_top;
  assign c_mon = c_day & (date_q == last_date);
  assign c_yr  = c_mon & (mon_q == 5'h12);

  assign sec_i  = bcd_inc({1'b0, sec_q});
  assign min_i  = bcd_inc({1'b0, min_q});
  assign hr_i   = bcd_inc({2'b0, hr_q});
  assign hr12_i = bcd_inc({3'b0, hr_q[4:0]});
  assign date_i = bcd_inc({2'b0, date_q});
  assign mon_i  = bcd_inc({3'b0, mon_q});
  assign yr_i   = bcd_inc(yr_q);

  always_comb begin
    case (mon_q)
      5'h02:                      last_date = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
      default:                    last_date = 6'h31;
    endcase
  end

  always_comb begin
    if (!ctrl_12h)                hr_nx = hr_top ? 6'h00 : hr_i[5:0];
    else if (hr_q[4:0] == 5'h12)  hr_nx = {hr_q[5], 5'h01};
    else if (hr_q[4:0] == 5'h11)  hr_nx = {~hr_q[5], 5'h12};
    else                          hr_nx = {hr_q[5], hr12_i[4:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_12h <= 1'b0; ctrl_stop <= 1'b0; osc_q <= 1'b1;
      sec_q <= '0; min_q <= '0; hr_q <= '0; date_q <= 6'h01;
      wd_q <= '0; mon_q <= 5'h01; yr_q <= '0;
    end else begin
      if (adv)   sec_q  <= (sec_q == 7'h59) ? 7'h00 : sec_i[6:0];
      if (c_min) min_q  <= (min_q == 7'h59) ? 7'h00 : min_i[6:0];
      if (c_hr)  hr_q   <= hr_nx;
      if (c_day) date_q <= (date_q == last_date) ? 6'h01 : date_i[5:0];
      if (c_day) wd_q   <= (wd_q == 3'd6) ? 3'd0 : wd_q + 3'd1;
      if (c_mon) mon_q  <= (mon_q == 5'h12) ? 5'h01 : mon_i[4:0];
      if (c_yr)  yr_q   <= (yr_q == 8'h99) ? 8'h00 : yr_i;
      if (wr_en) begin
        case (addr)
          A_CTRL: begin ctrl_12h <= wr_data[3]; ctrl_stop <= wr_data[5]; end
          A_SEC: begin
            sec_q <= wr_data[6:0];
            if (!wr_data[7]) osc_q <= 1'b0;
          end
          A_MIN:  min_q  <= wr_data[6:0];
          A_HR:   hr_q   <= wr_data[5:0];
          A_DATE: date_q <= wr_data[5:0];
          A_WD:   wd_q   <= wr_data[2:0];
          A_MON:  mon_q  <= wr_data[4:0];
          A_YR:   yr_q   <= wr_data;
          default: ;
        endcase
      end
      if (osc_fail) osc_q <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {2'b0, ctrl_stop, 1'b0, ctrl_12h, 3'b0};
      A_SEC:   rd_data = {osc_q, sec_q};
      A_MIN:   rd_data = {1'b0, min_q};
      A_HR:    rd_data = {2'b0, hr_q};
      A_DATE:  rd_data = {2'b0, date_q};
      A_WD:    rd_data = {5'b0, wd_q};
      A_MON:   rd_data = {3'b0, mon_q};
      A_YR:    rd_data = yr_q;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_regs_chk.sv
module bcd_calendar_regs_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic              osc_fail,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              ctrl_stop,
  input logic              osc_q,
  input logic [6:0]        sec_q,
  input logic [6:0]        min_q,
  input logic [5:0]        hr_q,
  input logic [5:0]        date_q,
  input logic [2:0]        wd_q,
  input logic [4:0]        mon_q,
  input logic [7:0]        yr_q
);
  logic [42:0] tvec;
  assign tvec = {sec_q, min_q, hr_q, date_q, wd_q, mon_q, yr_q};

  p_osc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> osc_q);

  p_osc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(3) && !wr_data[7] && !osc_fail) |=> !osc_q);

  p_stop_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_stop && !wr_en) |=> $stable(tvec));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !wr_en) |=> $stable(tvec));

  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !ctrl_stop && !wr_en && sec_q == 7'h59)
      |=> (sec_q == 7'h00 && min_q != $past(min_q)));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(3)) |=> (sec_q == $past(wr_data[6:0])));
endmodule

bind bcd_calendar_regs bcd_calendar_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_fail(osc_fail),
  .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .ctrl_stop(ctrl_stop),
  .osc_q(osc_q), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .date_q(date_q),
  .wd_q(wd_q), .mon_q(mon_q), .yr_q(yr_q)
);

// File: tb/bcd_calendar_regs_tb.sv
module bcd_calendar_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0, osc_fail = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_calendar_regs #(.ADDR_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_fail(osc_fail),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr 0x%02h got 0x%02h exp 0x%02h", tag, a, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic tick_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); tick_1hz = 1'b1; wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); tick_1hz = 1'b0; wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dt, wd, mo, y);
    wr(5'h03, s); wr(5'h04, mi); wr(5'h05, h); wr(5'h06, dt);
    wr(5'h07, wd); wr(5'h08, mo); wr(5'h09, y);
  endtask

  task automatic t_reset();
    chk(5'h00, 8'h00, "R1 ctrl"); chk(5'h03, 8'h80, "R1 sec");
    chk(5'h04, 8'h00, "R1 min");  chk(5'h05, 8'h00, "R1 hr");
    chk(5'h06, 8'h01, "R1 date"); chk(5'h07, 8'h00, "R1 wd");
    chk(5'h08, 8'h01, "R1 mon");  chk(5'h09, 8'h00, "R1 yr");
  endtask

  task automatic t_map();
    wr(5'h04, 8'hFF); chk(5'h04, 8'h7F, "R2 min mask");
    wr(5'h07, 8'hFF); chk(5'h07, 8'h07, "R2 wd mask");
    wr(5'h08, 8'hFF); chk(5'h08, 8'h1F, "R2 mon mask");
    wr(5'h01, 8'hFF); chk(5'h01, 8'h00, "R2 unmapped");
    chk(5'h0A, 8'h00, "R2 unmapped read");
    wr(5'h00, 8'hFF); chk(5'h00, 8'h28, "R2 ctrl mask");
    wr(5'h00, 8'h00);
  endtask

  task automatic t_secmin();
    set_time(8'h58, 8'h59, 8'h12, 8'h10, 8'h02, 8'h03, 8'h21);
    tick(); chk(5'h03, 8'h59, "R5 sec inc");
    tick(); chk(5'h03, 8'h00, "R5 sec wrap");
    chk(5'h04, 8'h00, "R5 min wrap"); chk(5'h05, 8'h13, "R5 hr carry");
    tick(); chk(5'h03, 8'h01, "R5 sec after wrap");
  endtask

  task automatic t_day24();
    set_time(8'h59, 8'h59, 8'h23, 8'h15, 8'h03, 8'h05, 8'h24);
    tick(); chk(5'h05, 8'h00, "R6 hr wrap");
    chk(5'h06, 8'h16, "R6 date inc"); chk(5'h07, 8'h04, "R9 wd inc");
  endtask

  task automatic t_months();
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h04, 8'h23);
    tick(); chk(5'h06, 8'h01, "R8 apr end"); chk(5'h08, 8'h05, "R8 apr->may");
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h05, 8'h23);
    tick(); chk(5'h06, 8'h31, "R8 may 31");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h23);
    tick(); chk(5'h06, 8'h01, "R8 feb nonleap"); chk(5'h08, 8'h03, "R8 feb->mar");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h01, 8'h02, 8'h24);
    tick(); chk(5'h06, 8'h29, "R8 feb leap 29");
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h01, 8'h02, 8'h00);
    tick(); chk(5'h06, 8'h01, "R8 feb leap 00 end"); chk(5'h08, 8'h03, "R8 leap mon");
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
    tick(); chk(5'h06, 8'h01, "R9 dec date"); chk(5'h08, 8'h01, "R9 mon wrap");
    chk(5'h09, 8'h00, "R9 yr wrap"); chk(5'h07, 8'h00, "R9 wd wrap");
  endtask

  task automatic t_twelve();
    wr(5'h00, 8'h08);
    set_time(8'h59, 8'h59, 8'h11, 8'h10, 8'h02, 8'h07, 8'h25);
    tick(); chk(5'h05, 8'h32, "R7 11am->12pm");
    chk(5'h06, 8'h10, "R7 no day carry at noon");
    set_time(8'h59, 8'h59, 8'h32, 8'h10, 8'h02, 8'h07, 8'h25);
    tick(); chk(5'h05, 8'h21, "R7 12pm->1pm");
    set_time(8'h59, 8'h59, 8'h31, 8'h10, 8'h02, 8'h07, 8'h25);
    tick(); chk(5'h05, 8'h12, "R7 11pm->12am"); chk(5'h06, 8'h11, "R7 day carry");
    wr(5'h00, 8'h00); chk(5'h05, 8'h12, "R7 no conversion");
  endtask

  task automatic t_stop();
    set_time(8'h10, 8'h20, 8'h05, 8'h10, 8'h02, 8'h07, 8'h25);
    wr(5'h00, 8'h20);
    tick(); tick(); chk(5'h03, 8'h10, "R4 frozen");
    wr(5'h04, 8'h33); chk(5'h04, 8'h33, "R4 write while stopped");
    wr(5'h00, 8'h00);
    tick(); chk(5'h03, 8'h11, "R4 resumed");
  endtask

  task automatic t_osc();
    @(negedge clk); osc_fail = 1'b1; @(negedge clk); osc_fail = 1'b0;
    chk(5'h03, 8'h91, "R3 flag set");
    wr(5'h03, 8'h85); chk(5'h03, 8'h85, "R3 write 1 keeps flag");
    wr(5'h03, 8'h05); chk(5'h03, 8'h05, "R3 write 0 clears");
    @(negedge clk); osc_fail = 1'b1; wr_en = 1'b1; addr = 5'h03; wr_data = 8'h07;
    @(negedge clk); osc_fail = 1'b0; wr_en = 1'b0;
    chk(5'h03, 8'h87, "R3 fail wins");
    wr(5'h03, 8'h00);
  endtask

  task automatic t_collide();
    set_time(8'h59, 8'h10, 8'h05, 8'h10, 8'h02, 8'h07, 8'h25);
    tick_wr(5'h04, 8'h30);
    chk(5'h03, 8'h00, "R10 other field advances");
    chk(5'h04, 8'h30, "R10 written min no carry");
    tick_wr(5'h03, 8'h20);
    chk(5'h03, 8'h20, "R10 written sec no advance");
    chk(5'h04, 8'h30, "R10 min unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_map(); t_secmin(); t_day24(); t_months();
    t_twelve(); t_stop(); t_osc(); t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule